// File: doc/BRIEF.md
# Single-Bit Test and Modify Execute Unit

This unit carries out the four single-bit instructions of a CPU with 16-bit opcodes: test a bit, invert a bit, clear a bit and set a bit. The address unit and register file around it supply three things: the opcode, the destination operand and the bit number. The bit number comes either as an immediate extension word or as the contents of a source data register. The outside address unit also supplies the effective-address cycle cost. One clock after a valid request, the unit returns the operand with the addressed bit updated, a write-back strobe, the condition codes with a new zero flag, and the instruction's cycle count.

A destination in data-register-direct mode is a full 32-bit word, and the bit number wraps at 32. Any other destination is a single memory byte placed in the low eight bits of the operand, and the bit number wraps at 8. The zero flag always reports the addressed bit as it was before the instruction changed it.

Top module: `bitop_unit`

## Requirements
- R1: Immediate form: an opcode whose bits [15:8] equal 8'h08 takes the operation from bits [7:6] (00 test, 01 invert, 10 clear, 11 set), the mode from bits [5:3] and the register from bits [2:0]. The bit number is `ext_word`.
- R2: Register form: an opcode with bits [15:12] equal to 0 and bit 8 equal to 1 uses the same bits [7:6], [5:3] and [2:0] coding as R1. The bit number is `src_data`, the contents of the data register named in bits [11:9].
- R3: With mode 0, the operand is all 32 bits of `dst_data` and the bit number is taken modulo 32. With any other legal mode, only `dst_data[7:0]` is addressed, the bit number is taken modulo 8, and bits [31:8] pass through unchanged.
- R4: `ccr_out` bit 2 (Z) is 1 when the addressed bit was 0 before the operation, and 0 when it was 1. Bits 4 (X), 3 (N), 1 (V) and 0 (C) are copied from `ccr_in`.
- R5: Invert flips the addressed bit, clear forces it to 0 and set forces it to 1. Test returns the operand unchanged. No other bit of the result differs from `dst_data`.
- R6: `wr_en` is 1 only on a legal invert, clear or set. It is never 1 for test.
- R7: All four operations use the same cycle counts. With a mode-0 destination, the count is 10 for the immediate form and 6 for the register form. With a memory destination, it is 8 + `ea_cycles` for the immediate form and 4 + `ea_cycles` for the register form.
- R8: `out_valid` is 1 exactly one clock after `in_valid` is 1, and 0 otherwise. Without `out_valid`, `wr_en` stays 0.
- R9: An opcode that matches neither form, or that uses mode 1, sets `illegal`. In that case `wr_en` is 0, `result` equals `dst_data`, `ccr_out` equals `ccr_in`, and `cycles` is 0.
- R10: While `rst` is high, and on the first clock after it, `out_valid`, `wr_en` and `illegal` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| opcode | input | 16 | Instruction word |
| ext_word | input | 16 | Immediate bit-number extension word |
| src_data | input | 32 | Contents of the source data register (register form) |
| dst_data | input | 32 | Destination operand (register, or memory byte in [7:0]) |
| ea_cycles | input | 8 | Effective-address cycle cost from the address unit |
| ccr_in | input | 5 | Current condition codes {X,N,Z,V,C} |
| out_valid | output | 1 | Result present |
| result | output | 32 | Updated operand |
| wr_en | output | 1 | Write the result back |
| ccr_out | output | 5 | Condition codes with the new Z |
| cycles | output | 8 | Instruction cycle count |
| illegal | output | 1 | Opcode not a legal bit instruction |

## Verification
Decode faults show up at the ports in the first output cycle after the request. A wrong operation field flips, clears or sets the wrong bit value. A wrong form selection picks the wrong bit number and the wrong cycle count. A bad mode decision wraps the bit number at the wrong width, so a bit number of 10 or 33 lands on a different bit. Because every output register is reloaded on each request, a stale internal value lasts exactly one output cycle and is caught in that cycle.

// File: rtl/bitop_pkg.sv
package bitop_pkg;
  typedef enum logic [1:0] {
    OP_TST = 2'b00,
    OP_CHG = 2'b01,
    OP_CLR = 2'b10,
    OP_SET = 2'b11
  } bitop_e;

  typedef struct packed {
    logic   legal;
    logic   imm_form;
    logic   reg_dst;
    bitop_e op;
  } bitop_dec_t;

  localparam int CCR_W = 5;
  localparam int CCR_Z = 2;
endpackage

// File: rtl/bitop_decode.sv
module bitop_decode
  import bitop_pkg::*;
(
  input  logic [15:0] opcode,
  output bitop_dec_t  dec
);
  logic       is_imm;
  logic       is_reg;
  logic [2:0] mode;

  always_comb begin
    mode   = opcode[5:3];
    is_imm = (opcode[15:8] == 8'h08);
    is_reg = (opcode[15:12] == 4'h0) && opcode[8];
    dec.legal    = (is_imm || is_reg) && (mode != 3'd1);
    dec.imm_form = is_imm;
    dec.reg_dst  = (mode == 3'd0);
    dec.op       = bitop_e'(opcode[7:6]);
  end
endmodule

// File: rtl/bitop_alu.sv
module bitop_alu
  import bitop_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic [DATA_W-1:0] operand,
  input  logic [DATA_W-1:0] bitnum,
  input  logic              reg_dst,
  input  bitop_e            op,
  output logic [DATA_W-1:0] res,
  output logic              was_zero
);
  localparam int IDX_W  = $clog2(DATA_W);
  localparam int BIDX_W = $clog2(BYTE_W);

  logic [IDX_W-1:0] idx;

  always_comb begin
    if (reg_dst) idx = bitnum[IDX_W-1:0];
    else         idx = {{(IDX_W-BIDX_W){1'b0}}, bitnum[BIDX_W-1:0]};
    was_zero = ~operand[idx];
  end

  for (genvar g = 0; g < DATA_W; g++) begin : g_bit
    logic hit;
    always_comb begin
      hit = (idx == IDX_W'(g));
      if (!hit) res[g] = operand[g];
      else begin
        unique case (op)
          OP_CHG:  res[g] = ~operand[g];
          OP_CLR:  res[g] = 1'b0;
          OP_SET:  res[g] = 1'b1;
          default: res[g] = operand[g];
        endcase
      end
    end
  end
endmodule

// File: rtl/bitop_cost.sv
module bitop_cost #(
  parameter int CYC_W   = 8,
  parameter int REG_IMM = 10,
  parameter int REG_REG = 6,
  parameter int MEM_IMM = 8,
  parameter int MEM_REG = 4
) (
  input  logic             imm_form,
  input  logic             reg_dst,
  input  logic [CYC_W-1:0] ea_cycles,
  output logic [CYC_W-1:0] cycles
);
  always_comb begin
    if (reg_dst) cycles = imm_form ? CYC_W'(REG_IMM) : CYC_W'(REG_REG);
    else         cycles = ea_cycles + (imm_form ? CYC_W'(MEM_IMM) : CYC_W'(MEM_REG));
  end
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
  import bitop_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int OPC_W  = 16,
  parameter int CYC_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [OPC_W-1:0]  opcode,
  input  logic [OPC_W-1:0]  ext_word,
  input  logic [DATA_W-1:0] src_data,
  input  logic [DATA_W-1:0] dst_data,
  input  logic [CYC_W-1:0]  ea_cycles,
  input  logic [CCR_W-1:0]  ccr_in,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              wr_en,
  output logic [CCR_W-1:0]  ccr_out,
  output logic [CYC_W-1:0]  cycles,
  output logic              illegal
);
  bitop_dec_t        dec;
  logic [DATA_W-1:0] bitnum;
  logic [DATA_W-1:0] alu_res;
  logic              alu_zero;
  logic [CYC_W-1:0]  cost;

  bitop_decode u_dec (.opcode(opcode[15:0]), .dec(dec));

  assign bitnum = dec.imm_form ? DATA_W'(ext_word) : src_data;

  bitop_alu #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_alu (
    .operand(dst_data), .bitnum(bitnum), .reg_dst(dec.reg_dst),
    .op(dec.op), .res(alu_res), .was_zero(alu_zero)
  );

  bitop_cost #(.CYC_W(CYC_W)) u_cost (
    .imm_form(dec.imm_form), .reg_dst(dec.reg_dst),
    .ea_cycles(ea_cycles), .cycles(cost)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      wr_en     <= 1'b0;
      illegal   <= 1'b0;
      result    <= '0;
      ccr_out   <= '0;
      cycles    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        illegal <= ~dec.legal;
        if (dec.legal) begin
          result  <= alu_res;
          wr_en   <= (dec.op != OP_TST);
          ccr_out <= ccr_in;
          ccr_out[CCR_Z] <= alu_zero;
          cycles  <= cost;
        end else begin
          result  <= dst_data;
          wr_en   <= 1'b0;
          ccr_out <= ccr_in;
          cycles  <= '0;
        end
      end else begin
        wr_en   <= 1'b0;
        illegal <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/bitop_unit_chk.sv
module bitop_unit_chk #(
  parameter int DATA_W = 32,
  parameter int CYC_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [15:0]       opcode,
  input logic [DATA_W-1:0] dst_data,
  input logic [4:0]        ccr_in,
  input logic              out_valid,
  input logic [DATA_W-1:0] result,
  input logic              wr_en,
  input logic [4:0]        ccr_out,
  input logic              illegal
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R8
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R8
  AST_WR_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> out_valid); // R8
  AST_TEST_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && opcode[7:6] == 2'b00) |=> !wr_en); // R6
  AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    illegal |-> !wr_en); // R9
  AST_FLAGS_KEPT: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ({ccr_out[4:3], ccr_out[1:0]} == $past({ccr_in[4:3], ccr_in[1:0]}))); // R4
  AST_ONE_BIT_ONLY: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($countones(result ^ $past(dst_data)) <= 1)); // R5
endmodule

bind bitop_unit bitop_unit_chk #(.DATA_W(DATA_W), .CYC_W(CYC_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode[15:0]),
  .dst_data(dst_data), .ccr_in(ccr_in), .out_valid(out_valid),
  .result(result), .wr_en(wr_en), .ccr_out(ccr_out), .illegal(illegal)
);

// File: tb/bitop_unit_bench.sv
module bitop_unit_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [15:0] opcode, ext_word;
  logic [31:0] src_data, dst_data;
  logic [7:0]  ea_cycles;
  logic [4:0]  ccr_in;
  logic        out_valid, wr_en, illegal;
  logic [31:0] result;
  logic [4:0]  ccr_out;
  logic [7:0]  cycles;

  int n_checks = 0;
  int n_errors = 0;

  always #5 clk = ~clk;

  bitop_unit u_bitop_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode),
    .ext_word(ext_word), .src_data(src_data), .dst_data(dst_data),
    .ea_cycles(ea_cycles), .ccr_in(ccr_in), .out_valid(out_valid),
    .result(result), .wr_en(wr_en), .ccr_out(ccr_out), .cycles(cycles),
    .illegal(illegal)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Present one request at a falling edge; sample the outputs at the next falling edge.
  task automatic issue(input logic [15:0] op, input logic [15:0] ext, input logic [31:0] src,
                       input logic [31:0] dst, input logic [7:0] ea, input logic [4:0] cc);
    @(negedge clk);
    in_valid = 1'b1; opcode = op; ext_word = ext; src_data = src;
    dst_data = dst; ea_cycles = ea; ccr_in = cc;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset;
    rst = 1'b1; in_valid = 1'b0; opcode = '0; ext_word = '0;
    src_data = '0; dst_data = '0; ea_cycles = '0; ccr_in = '0;
    repeat (3) @(negedge clk);
    chk("R10 out_valid", 32'(out_valid), 0);
    chk("R10 wr_en", 32'(wr_en), 0);
    chk("R10 illegal", 32'(illegal), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 idle after reset", 32'(out_valid), 0);
  endtask

  // Set bit, immediate form, register destination: 33 wraps to bit 1.
  task automatic t_set_imm_reg;
    issue(16'h08C3, 16'd33, 32'hFFFF_FFFF, 32'h0000_0000, 8'd7, 5'b11011);
    chk("R8 out_valid", 32'(out_valid), 1);
    chk("R1/R3 set wraps mod 32", result, 32'h0000_0002);
    chk("R4 Z when bit was 0", 32'(ccr_out), 32'(5'b11111));
    chk("R6 set writes", 32'(wr_en), 1);
    chk("R7 reg dst imm cycles", 32'(cycles), 10);
    chk("R9 legal", 32'(illegal), 0);
  endtask

  // Clear bit, register form, memory byte: bit number 10 wraps to bit 2.
  task automatic t_clr_reg_mem;
    issue(16'h0B90, 16'd0, 32'd10, 32'hAAAA_00FF, 8'd6, 5'b00100);
    chk("R2/R3 clear mod 8", result, 32'hAAAA_00FB);
    chk("R4 Z clear when bit was 1", 32'(ccr_out), 32'(5'b00000));
    chk("R7 mem dst reg cycles", 32'(cycles), 10);
    chk("R6 clear writes", 32'(wr_en), 1);
  endtask

  // Invert, immediate form, memory byte: 0xF3 wraps to bit 3, then bit 7.
  task automatic t_chg_imm_mem;
    issue(16'h086A, 16'h00F3, 32'd0, 32'h1234_5600, 8'd2, 5'b00000);
    chk("R5 change sets 0 bit", result, 32'h1234_5608);
    chk("R7 mem dst imm cycles", 32'(cycles), 10);
    chk("R4 Z before change", 32'(ccr_out[2]), 1);
    issue(16'h086A, 16'd15, 32'd0, 32'h1234_56FF, 8'd4, 5'b00000);
    chk("R3 upper bits kept, R5 change clears 1 bit", result, 32'h1234_567F);
    chk("R7 mem imm cycles ea4", 32'(cycles), 12);
  endtask

  // Test, register form, register destination bit 31.
  task automatic t_test;
    issue(16'h0304, 16'd0, 32'd31, 32'h8000_0000, 8'd9, 5'b10101);
    chk("R5 test leaves operand", result, 32'h8000_0000);
    chk("R6 test no write", 32'(wr_en), 0);
    chk("R4 test Z and flags", 32'(ccr_out), 32'(5'b10001));
    chk("R7 reg dst reg cycles", 32'(cycles), 6);
  endtask

  // Set on an already-set bit.
  task automatic t_set_again;
    issue(16'h0FC1, 16'd0, 32'd4, 32'h0000_0010, 8'd0, 5'b00100);
    chk("R5 set keeps set bit", result, 32'h0000_0010);
    chk("R4 Z 0 when bit set", 32'(ccr_out[2]), 0);
    chk("R2 reg form set writes", 32'(wr_en), 1);
  endtask

  task automatic t_illegal;
    issue(16'h08C8, 16'd1, 32'd0, 32'h5555_5555, 8'd3, 5'b01010);
    chk("R9 mode 1 illegal", 32'(illegal), 1);
    chk("R9 no write", 32'(wr_en), 0);
    chk("R9 result unchanged", result, 32'h5555_5555);
    chk("R9 ccr unchanged", 32'(ccr_out), 32'(5'b01010));
    chk("R9 cycles zero", 32'(cycles), 0);
    issue(16'h4E71, 16'd0, 32'd0, 32'h0000_0001, 8'd3, 5'b00000);
    chk("R9 non-matching opcode", 32'(illegal), 1);
    chk("R9 non-matching no write", 32'(wr_en), 0);
  endtask

  task automatic t_gap;
    @(negedge clk);
    chk("R8 no valid without request", 32'(out_valid), 0);
    chk("R8 no write without request", 32'(wr_en), 0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_set_imm_reg();
        t_clr_reg_mem();
        t_chg_imm_mem();
        t_test();
        t_set_again();
        t_illegal();
        t_gap();
      end
      begin
        repeat (5000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule